// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

This block is a 16-bit timer and event counter. Its count lives in two 8-bit halves. A carry out of the low half steps the high half, and a borrow out of the low half steps it back. The step source is chosen by a control bit. One choice is a strobe taken from the module clock divided by six. The other is the falling edge of an external count pin, which first passes through a two-flop synchronizer. A run bit gates all stepping.

When the up/down enable bit is clear, the block counts upward only. When it is set, a synchronized direction pin chooses the direction: high counts up, low counts down.

- **Counting up:** a step from FFFFh loads the 16-bit reload value.
- **Counting down:** a step taken while the count equals the reload value loads FFFFh.

Either kind of wrap sets a sticky interrupt flag and toggles a wrap bit, which serves as a 17th count bit.

Software reaches the block through a byte-wide register write port.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset the count, the reload value, the interrupt output and the wrap bit are all zero.
- R2: Control register (address 0) fields:
  - bit 0 is run;
  - bit 1 selects the external pin source;
  - bit 2 enables up/down control;
  - bit 6 is the wrap bit;
  - bit 7 is the interrupt flag.

  In clock-source mode, the first step lands on the 7th rising edge after the edge that writes run high. Steps then follow every 6 clock cycles.
- R3: While run is 0 the count holds its value.
- R4: In pin-source mode, a falling edge of the count pin is held pending until the next prescaler strobe. At most one step is taken per 6-cycle strobe period, so two falling edges within one period give a single step.
- R5: The count is two cascaded halves. The low half sits at address 1 and the high half at address 2. A carry from the low half steps the high half up (00FFh to 0100h), and a borrow steps it down (0100h to 00FFh).
- R6: Counting up, a step from FFFFh loads the reload value (low byte at address 3, high byte at address 4) and sets the interrupt flag.
- R7: Counting down, a step taken while the count equals the reload value loads FFFFh and sets the interrupt flag. Other down steps subtract one.
- R8: With up/down enable set, the direction pin chooses the direction: high counts up, low counts down. With up/down enable clear, the count goes up whatever the pin level.
- R9: The wrap bit toggles on every overflow and every underflow. Setting it does not raise the interrupt output.
- R10: The interrupt output follows the interrupt flag. The flag stays set until a control register write clears it.
- R11: A write to either count half takes effect on the next edge and suppresses any count step in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 control, 1/2 count low/high, 3/4 reload low/high) |
| wr_data_i | input | 8 | Register write data |
| t_ext_i | input | 1 | External count pin (asynchronous) |
| dir_i | input | 1 | Direction pin (asynchronous), high is up |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Current reload value |
| irq_o | output | 1 | Interrupt request (interrupt flag) |
| wrap_bit_o | output | 1 | Wrap bit, the 17th count bit |

## Verification
The counting function is swept over start values placed on both sides of FFFFh, of the low-half boundary and of the reload value. Each sweep runs in three settings:
- forced-up mode with the direction pin low, which separates R8's override from pin-driven counting;
- pin-selected up mode;
- pin-selected down mode.

The expected count, the interrupt state and the wrap-bit parity are computed step by step with plain arithmetic. This separates an overflow reload from an underflow fill, and a carry from a borrow.

The pin-source mode is driven two ways. Widely spaced falling edges must each count once. A tight burst inside one prescaler period must count exactly once.

A count write placed on a step edge shows whether the write wins over the step.

// File: rtl/urt_pkg.sv
package urt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_EXT  = 1;
  localparam int unsigned B_UPDN = 2;
  localparam int unsigned B_WRAP = 6;
  localparam int unsigned B_FLAG = 7;

  typedef struct packed {
    logic run;
    logic ext_sel;
    logic updn_en;
    logic wrap;
    logic flag;
  } ctrl_t;
endpackage

// File: rtl/urt_sync.sv
module urt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = pin_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/urt_prescale.sv
module urt_prescale #(
  parameter int unsigned DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic pulse_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q;
  logic          restart;

  always_comb begin
    restart = run_i & ~run_q;
    if (restart || cnt_q == LAST) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_i;
    end
  end

  assign pulse_o = run_i & ~restart & (cnt_q == LAST);

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !run_q) |=> (cnt_q == '0));
endmodule

// File: rtl/urt_edge_pend.sv
module urt_edge_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic consume_i,
  output logic pend_o
);
  logic prev_q, pend_q;
  logic fall, pend_d;

  always_comb begin
    fall   = prev_q & ~lvl_i;
    pend_d = fall | (pend_q & ~consume_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  a_r4_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_i && !(prev_q && !lvl_i)) |=> !pend_q);
  a_r4_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q && !lvl_i) |=> pend_q);
endmodule

// File: rtl/urt_count_core.sv
module urt_count_core
  import urt_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [HALF_W-1:0]     wr_data_i,
  input  logic                  step_i,
  input  logic                  up_i,
  output logic [2*HALF_W-1:0]   count_o,
  output logic [2*HALF_W-1:0]   reload_o,
  output ctrl_t                 ctrl_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [HALF_W-1:0] rlo_q, rlo_d, rhi_q, rhi_d;
  ctrl_t             ctl_q, ctl_d;
  logic              wr_ctl, wr_lo, wr_hi, cnt_wr;
  logic              at_top, at_rld, wrap, do_step;

  always_comb begin
    wr_ctl  = wr_en_i && (wr_addr_i == A_CTRL);
    wr_lo   = wr_en_i && (wr_addr_i == A_CNT_LO);
    wr_hi   = wr_en_i && (wr_addr_i == A_CNT_HI);
    cnt_wr  = wr_lo | wr_hi;
    do_step = step_i & ~cnt_wr;
    at_top  = ({hi_q, lo_q} == {CNT_W{1'b1}});
    at_rld  = ({hi_q, lo_q} == {rhi_q, rlo_q});
    wrap    = do_step & (up_i ? at_top : at_rld);

    lo_d  = lo_q;
    hi_d  = hi_q;
    rlo_d = rlo_q;
    rhi_d = rhi_q;
    ctl_d = ctl_q;

    if (wrap) begin
      if (up_i) begin
        lo_d = rlo_q;
        hi_d = rhi_q;
      end else begin
        lo_d = '1;
        hi_d = '1;
      end
    end else if (do_step) begin
      if (up_i) begin
        lo_d = lo_q + 1'b1;
        hi_d = hi_q + {{(HALF_W-1){1'b0}}, (lo_q == {HALF_W{1'b1}})};
      end else begin
        lo_d = lo_q - 1'b1;
        hi_d = hi_q - {{(HALF_W-1){1'b0}}, (lo_q == '0)};
      end
    end

    ctl_d.flag = ctl_q.flag | wrap;
    ctl_d.wrap = ctl_q.wrap ^ wrap;

    if (wr_lo) lo_d = wr_data_i;
    if (wr_hi) hi_d = wr_data_i;
    if (wr_en_i && wr_addr_i == A_RLD_LO) rlo_d = wr_data_i;
    if (wr_en_i && wr_addr_i == A_RLD_HI) rhi_d = wr_data_i;
    if (wr_ctl) begin
      ctl_d.run     = wr_data_i[B_RUN];
      ctl_d.ext_sel = wr_data_i[B_EXT];
      ctl_d.updn_en = wr_data_i[B_UPDN];
      ctl_d.wrap    = wr_data_i[B_WRAP];
      ctl_d.flag    = wr_data_i[B_FLAG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      rlo_q <= '0;
      rhi_q <= '0;
      ctl_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      rlo_q <= rlo_d;
      rhi_q <= rhi_d;
      ctl_q <= ctl_d;
    end
  end

  assign count_o  = {hi_q, lo_q};
  assign reload_o = {rhi_q, rlo_q};
  assign ctrl_o   = ctl_q;

  a_r6_up_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && up_i && !cnt_wr && count_o == {CNT_W{1'b1}}) |=> (count_o == $past(reload_o)));
  a_r7_down_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !up_i && !cnt_wr && count_o == reload_o) |=> (count_o == {CNT_W{1'b1}}));
  a_r9_wrap_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && up_i && !wr_en_i && count_o == {CNT_W{1'b1}}) |=> (ctrl_o.wrap != $past(ctrl_o.wrap)));
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o.flag && !wr_ctl) |=> ctrl_o.flag);
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (count_o[HALF_W-1:0] == $past(wr_data_i)));
  a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && up_i && !cnt_wr && count_o == 16'h00FF) |=> (count_o == 16'h0100));
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import urt_pkg::*;
#(
  parameter int unsigned HALF_W   = 8,
  parameter int unsigned PRE_DIV  = 6,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [2:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  t_ext_i,
  input  logic                  dir_i,
  output logic [15:0]           count_o,
  output logic [15:0]           reload_o,
  output logic                  irq_o,
  output logic                  wrap_bit_o
);
  ctrl_t ctl;
  logic  ext_lvl, dir_lvl, pre_pulse, pend, consume, step, up;

  urt_sync #(.STAGES(SYNC_STG)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(t_ext_i), .lvl_o(ext_lvl));
  urt_sync #(.STAGES(SYNC_STG)) u_dir_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(dir_i), .lvl_o(dir_lvl));
  urt_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(ctl.run), .pulse_o(pre_pulse));
  urt_edge_pend u_pend (
    .clk(clk), .rst_n(rst_n), .lvl_i(ext_lvl), .consume_i(consume), .pend_o(pend));

  always_comb begin
    consume = pre_pulse & ctl.ext_sel;
    step    = pre_pulse & (ctl.ext_sel ? pend : 1'b1);
    up      = ~ctl.updn_en | dir_lvl;
  end

  urt_count_core #(.HALF_W(HALF_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .step_i(step), .up_i(up),
    .count_o(count_o), .reload_o(reload_o), .ctrl_o(ctl));

  assign irq_o      = ctl.flag;
  assign wrap_bit_o = ctl.wrap;

  a_r3_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !wr_en_i) |=> $stable(count_o));
  a_r8_forced_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.updn_en && step && !wr_en_i && count_o != 16'hFFFF) |=> (count_o == $past(count_o) + 16'd1));
endmodule

// File: tb/updn_reload_timer_test.sv
`timescale 1ns/1ps
module updn_reload_timer_test;
  logic        clk, rst_n, wr_en, t_ext, dir;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] count, reload;
  logic        irq, wrap_bit;
  int          n_chk, n_bad;
  bit          done;

  updn_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .t_ext_i(t_ext), .dir_i(dir), .count_o(count), .reload_o(reload),
    .irq_o(irq), .wrap_bit_o(wrap_bit));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One sweep trial: load, run K steps in clock-source mode, compare with arithmetic.
  task automatic trial(input logic [15:0] start, input logic [15:0] rv,
                       input bit updn, input bit d, input int k, input string req);
    logic [15:0] v;
    bit up, par, flag;
    dir = d;
    wr(3'd0, 8'h00);
    wr(3'd1, start[7:0]);
    wr(3'd2, start[15:8]);
    wr(3'd3, rv[7:0]);
    wr(3'd4, rv[15:8]);
    wr(3'd0, {5'b0, updn, 1'b0, 1'b1});
    idle(6 * k + 1);
    up = !updn || d;
    v = start; par = 0; flag = 0;
    for (int i = 0; i < k; i++) begin
      if (up && v == 16'hFFFF)      begin v = rv;        par = !par; flag = 1; end
      else if (!up && v == rv)      begin v = 16'hFFFF;  par = !par; flag = 1; end
      else if (up)                  v = v + 16'd1;
      else                          v = v - 16'd1;
    end
    chk({req, " count"}, 32'(count), 32'(v));
    chk("R10 irq", 32'(irq), 32'(flag));
    chk("R9 wrap bit", 32'(wrap_bit), 32'(par));
    wr(3'd0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] held;
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; t_ext = 1'b1; dir = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 reload", 32'(reload), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 wrap", 32'(wrap_bit), 32'h0);

    // R2 timing: first step on 7th edge, then every 6
    wr(3'd0, 8'h01);
    idle(6);
    chk("R2 before first step", 32'(count), 32'h0);
    idle(1);
    chk("R2 first step", 32'(count), 32'h1);
    idle(5);
    chk("R2 mid period", 32'(count), 32'h1);
    idle(1);
    chk("R2 second step", 32'(count), 32'h2);

    // R3 hold while run clear
    wr(3'd0, 8'h00);
    held = count;
    idle(40);
    chk("R3 hold", 32'(count), 32'(held));

    // Sweeps: R6/R8 forced up with pin low, R5 carry, R8 pin up, R7 down
    for (int s = 0; s < 8; s++)
      trial(16'hFFFB + 16'(s), 16'h1234, 1'b0, 1'b0, 5, "R6 R8 forced up");
    for (int s = 0; s < 6; s++)
      trial(16'h00FC + 16'(s), 16'h0000, 1'b1, 1'b1, 4, "R5 R8 pin up");
    for (int s = 0; s < 8; s++)
      trial(16'h0100 + 16'(s), 16'h00FE, 1'b1, 1'b0, 5, "R7 R5 down");
    trial(16'h0003, 16'h0003, 1'b1, 1'b0, 3, "R7 equal at start");

    // R10 sticky flag, then cleared by control write
    trial(16'hFFFF, 16'h0000, 1'b0, 1'b0, 1, "R6 single wrap");
    chk("R10 cleared", 32'(irq), 32'h0);
    wr(3'd0, 8'h80);
    idle(20);
    chk("R10 sticky", 32'(irq), 32'h1);
    // R9 wrap bit alone raises no irq
    wr(3'd0, 8'h40);
    chk("R9 wrap set", 32'(wrap_bit), 32'h1);
    chk("R9 no irq", 32'(irq), 32'h0);

    // R11 write on a step edge wins
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);
    idle(5);
    wr(3'd1, 8'h55);
    chk("R11 write wins", 32'(count), 32'h0055);
    wr(3'd0, 8'h00);

    // R4 burst of two falls within one period gives one step
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h03);
    idle(7);
    t_ext = 1'b0; idle(1);
    t_ext = 1'b1; idle(1);
    t_ext = 1'b0; idle(1);
    t_ext = 1'b1;
    idle(20);
    chk("R4 burst single", 32'(count), 32'h1);
    // R4 spaced edges each counted
    for (int m = 0; m < 5; m++) begin
      t_ext = 1'b0; idle(6);
      t_ext = 1'b1; idle(6);
    end
    idle(20);
    chk("R4 spaced edges", 32'(count), 32'h6);
    wr(3'd0, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule